// File: doc/BRIEF.md
# Triggered Fan Tachometer Period Meter

The block measures the pulse period of one fan tachometer input, chosen from a bank of inputs. Each run is started by a write to the trigger word. Every tach input is resynchronised to the system clock through two flops and then edge-detected. A selectable edge mode picks which edges count: falling, rising, or any edge. A selectable prescaler divides the system clock into counting ticks. The unit counts prescaled ticks between two consecutive qualifying edges on the chosen channel. It then publishes a result word that carries a completion flag above the count.

Software first writes zero to the trigger word, which clears the flag and abandons any run. It then writes a value with exactly one bit set, which starts a run on that channel if the channel's enable bit is set. A run-time window, given in measurement units, bounds each run. If the second qualifying edge does not arrive inside the window, the run completes with a count of zero, which software reads as a stopped fan. Converting the count to revolutions per minute is left to software. The trigger and the result are plain control and status words. Neither one takes part in any handshake, and neither applies back-pressure: a trigger write is acted on in the cycle after it is presented, and the result is valid whenever its flag is set.

Top module: `fan_tach_meter`

## Requirements
- R1: After reset the result word is all zeros, and it stays zero until a run completes.
- R2: A trigger write with exactly one bit set, on a channel whose enable bit is set, starts a run on that channel. Any trigger write clears the completion flag in the following cycle. A write of zero abandons a run in progress, and no result appears for it.
- R3: A trigger write with more than one bit set, or one naming a disabled channel, starts no run. The result stays all zeros however the tach inputs toggle and however long the wait.
- R4: The tick period is P = 4 << (2 × clk_div) clock cycles, which is 4, 16, 64 or 256. For qualifying edges D cycles apart, the count is floor(D / P).
- R5: Edge mode 2'b00 measures between two consecutive falling edges. Rising edges in between are ignored.
- R6: Edge mode 2'b01 measures between two consecutive rising edges. Falling edges in between are ignored.
- R7: Edge mode 2'b10 measures between two consecutive edges of either polarity.
- R8: Edge mode 2'b11 is reserved, and no edge qualifies. The run ends at the window with a count of zero.
- R9: The window is window_units × 2^WIN_SHIFT × P clock cycles, counted from the trigger write. If no second qualifying edge arrives before the window ends, the run completes with count zero. The run does not complete before that.
- R10: The count saturates at all ones of its CNT_W bits and does not wrap.
- R11: The result word has the completion flag in bit 31 and the count in bits CNT_W-1:0. All other bits read zero. A completed result holds unchanged until the next trigger write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tach_in | input | NUM_CH | Asynchronous tachometer inputs |
| ch_enable | input | NUM_CH | Per-channel enable; a run may start only on a set bit |
| edge_mode | input | 2 | 00 falling, 01 rising, 10 any edge, 11 reserved |
| clk_div | input | DIV_W | Prescaler select, P = 4 << (2 × clk_div) |
| window_units | input | UNIT_W | Run window in units of 2^WIN_SHIFT ticks |
| trig_wr | input | 1 | Trigger word write strobe |
| trig_data | input | NUM_CH | Trigger word value, one bit per channel |
| result | output | 32 | Bit 31 completion flag, low CNT_W bits the count |

## Verification
The bench builds the block with four channels, an 8-bit count, an 8-bit window field and a window shift of 4. The narrow count lets a gap of about 1500 cycles at the finest prescale drive the count into saturation. The short window lets expiry, the reserved mode and mistaken starts finish within a few hundred cycles. All four prescale settings and all three working edge modes appear in the vector table. One channel is left disabled, so that refused starts can be seen at the result word.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_ARM   = 2'd1,
    MS_COUNT = 2'd2,
    MS_DONE  = 2'd3
  } meas_state_t;

  typedef enum logic [1:0] {
    EM_FALL = 2'b00,
    EM_RISE = 2'b01,
    EM_ANY  = 2'b10,
    EM_RSVD = 2'b11
  } edge_mode_t;

  localparam int DONE_BIT = 31;

  // Width of a counter that spans the largest prescale factor
  function automatic int pre_width(input int div_w);
    return 2 + 2 * ((1 << div_w) - 1);
  endfunction
endpackage

// File: rtl/tach_edge_detect.sv
module tach_edge_detect #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tach_in,
  output logic [NUM_CH-1:0] rise,
  output logic [NUM_CH-1:0] fall
);
  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic meta_q, sync_q, prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b0;
          sync_q <= 1'b0;
          prev_q <= 1'b0;
        end else begin
          meta_q <= tach_in[g];
          sync_q <= meta_q;
          prev_q <= sync_q;
        end
      end
      assign rise[g] = sync_q & ~prev_q;
      assign fall[g] = ~sync_q & prev_q;
    end
  endgenerate
endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler
  import fan_tach_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PRE_W = pre_width(DIV_W);

  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] last;
  logic [PRE_W-1:0] pre_q;

  always_comb begin
    span = (PRE_W+1)'(1) << (2 + 2 * int'(div));
    last = PRE_W'(span - 1'b1);
  end

  assign tick = run && (pre_q == last);

  // Restart loads 1 so the restart cycle itself counts toward the first tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_q <= '0;
    else if (restart)  pre_q <= PRE_W'(1);
    else if (run)      pre_q <= tick ? '0 : pre_q + 1'b1;
  end

  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(div)) |-> (pre_q <= last)); // R4
endmodule

// File: rtl/tach_window.sv
module tach_window
  import fan_tach_pkg::*;
#(
  parameter int UNIT_W    = 16,
  parameter int WIN_SHIFT = 4,
  parameter int DIV_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic [UNIT_W-1:0] units,
  input  logic [DIV_W-1:0]  div,
  output logic              expired
);
  localparam int WW = UNIT_W + WIN_SHIFT + pre_width(DIV_W);

  logic [WW-1:0] limit;
  logic [WW-1:0] wcnt_q;

  assign limit   = WW'(units) << (WIN_SHIFT + 2 + 2 * int'(div));
  assign expired = run && (wcnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wcnt_q <= '0;
    else if (clear)            wcnt_q <= '0;
    else if (run && !expired)  wcnt_q <= wcnt_q + 1'b1;
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear && $stable(units) && $stable(div)) |=> (wcnt_q <= limit)); // R9
endmodule

// File: rtl/fan_tach_meter.sv
module fan_tach_meter
  import fan_tach_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int CNT_W     = 20,
  parameter int UNIT_W    = 16,
  parameter int WIN_SHIFT = 4,
  parameter int DIV_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tach_in,
  input  logic [NUM_CH-1:0] ch_enable,
  input  logic [1:0]        edge_mode,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [UNIT_W-1:0] window_units,
  input  logic              trig_wr,
  input  logic [NUM_CH-1:0] trig_data,
  output logic [31:0]       result
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  meas_state_t       state_q;
  logic [CH_W-1:0]   sel_q, wr_idx;
  logic [CNT_W-1:0]  cnt_q, res_q;
  logic [NUM_CH-1:0] rise, fall;
  logic              single_bit, start_ok, qual, tick, expired, restart;

  tach_edge_detect #(.NUM_CH(NUM_CH)) u_edge (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .rise(rise), .fall(fall));

  always_comb begin
    wr_idx = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (trig_data[i]) wr_idx = CH_W'(i);
  end

  assign single_bit = (trig_data != '0) && ((trig_data & (trig_data - 1'b1)) == '0);
  assign start_ok   = single_bit && ((trig_data & ch_enable) != '0);

  always_comb begin
    case (edge_mode_t'(edge_mode))
      EM_FALL: qual = fall[sel_q];
      EM_RISE: qual = rise[sel_q];
      EM_ANY:  qual = fall[sel_q] | rise[sel_q];
      default: qual = 1'b0;
    endcase
  end

  assign restart = (state_q == MS_ARM) && !trig_wr && !expired && qual;

  tach_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .run(state_q == MS_COUNT), .div(clk_div), .tick(tick));

  tach_window #(.UNIT_W(UNIT_W), .WIN_SHIFT(WIN_SHIFT), .DIV_W(DIV_W)) u_win (
    .clk(clk), .rst_n(rst_n), .clear(trig_wr),
    .run((state_q == MS_ARM) || (state_q == MS_COUNT)),
    .units(window_units), .div(clk_div), .expired(expired));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
      sel_q   <= '0;
      cnt_q   <= '0;
      res_q   <= '0;
    end else if (trig_wr) begin
      state_q <= start_ok ? MS_ARM : MS_IDLE;
      sel_q   <= wr_idx;
      cnt_q   <= '0;
      res_q   <= '0;
    end else begin
      case (state_q)
        MS_ARM: begin
          if (expired) begin
            state_q <= MS_DONE;
            res_q   <= '0;
          end else if (qual) begin
            state_q <= MS_COUNT;
            cnt_q   <= '0;
          end
        end
        MS_COUNT: begin
          if (qual) begin
            state_q <= MS_DONE;
            res_q   <= cnt_q;
          end else if (expired) begin
            state_q <= MS_DONE;
            res_q   <= '0;
          end else if (tick && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  logic done;
  assign done = (state_q == MS_DONE);

  always_comb begin
    result = '0;
    result[DONE_BIT]    = done;
    result[CNT_W-1:0]   = res_q;
  end

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !trig_wr) |=> (done && $stable(res_q))); // R11
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr |=> !result[DONE_BIT]); // R2
  AST_NO_BAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && !single_bit) |=> (state_q == MS_IDLE)); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MS_COUNT && !trig_wr) |=> (cnt_q >= $past(cnt_q))); // R10
  AST_RSVD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MS_ARM && edge_mode == 2'b11 && !trig_wr) |=> (state_q != MS_COUNT)); // R8
endmodule

// File: tb/fan_tach_meter_tb_top.sv
module fan_tach_meter_tb_top;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int UW  = 8;
  localparam int WS  = 4;
  localparam int DW  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NCH-1:0] tach = '0;
  logic [NCH-1:0] ch_en = 4'b1011;
  logic [1:0]    mode = 2'b00;
  logic [DW-1:0] div = '0;
  logic [UW-1:0] units = '0;
  logic          twr = 1'b0;
  logic [NCH-1:0] tdata = '0;
  logic [31:0]   result;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  fan_tach_meter #(.NUM_CH(NCH), .CNT_W(CW), .UNIT_W(UW), .WIN_SHIFT(WS), .DIV_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tach_in(tach), .ch_enable(ch_en), .edge_mode(mode),
    .clk_div(div), .window_units(units), .trig_wr(twr), .trig_data(tdata), .result(result));

  // vector table: mode, divider, channel, edge gap in cycles
  localparam int NV = 7;
  localparam int VM[NV] = '{0, 1, 2, 2, 0, 1, 0};
  localparam int VD[NV] = '{0, 0, 1, 0, 2, 3, 1};
  localparam int VC[NV] = '{0, 1, 3, 3, 1, 0, 3};
  localparam int VG[NV] = '{100, 103, 170, 37, 640, 1000, 15};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trig(input logic [NCH-1:0] v);
    @(negedge clk);
    twr = 1'b1;
    tdata = v;
    @(negedge clk);
    twr = 1'b0;
    tdata = '0;
  endtask

  task automatic wait_done(input int maxc);
    for (int i = 0; i < maxc; i++) begin
      if (result[31]) break;
      @(negedge clk);
    end
  endtask

  // idle level, trigger, first edge, opposite edge halfway, second edge
  task automatic measure(input int m, input int d, input int ch, input int gap, input int u);
    logic lvl;
    mode = m[1:0];
    div = d[DW-1:0];
    units = u[UW-1:0];
    lvl = (m == 1) ? 1'b0 : 1'b1;
    tach[ch] = lvl;
    cyc(5);
    trig('0);
    trig(NCH'(1) << ch);
    cyc(3);
    tach[ch] = ~lvl;
    if (m == 2) begin
      cyc(gap);
      tach[ch] = lvl;
    end else begin
      cyc(gap / 2);
      tach[ch] = lvl;
      cyc(gap - gap / 2);
      tach[ch] = ~lvl;
    end
  endtask

  function automatic string mode_req(input int m);
    case (m)
      0: return "R5/R4";
      1: return "R6/R4";
      default: return "R7/R4";
    endcase
  endfunction

  initial begin
    cyc(1);
    check("R1 in reset", result, 32'h0);
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
    check("R1 after reset", result, 32'h0);

    // table-driven period measurements (R4 R5 R6 R7 R11)
    for (int v = 0; v < NV; v++) begin
      int p;
      p = 4 << (2 * VD[v]);
      measure(VM[v], VD[v], VC[v], VG[v], 200);
      wait_done(3000);
      check(mode_req(VM[v]), result, {1'b1, 23'b0, 8'(VG[v] / p)});
    end

    // R8 reserved mode: edges ignored, expires with zero
    measure(3, 0, 0, 20, 2);
    cyc(200);
    check("R8 reserved mode", result, 32'h8000_0000);

    // R9 window expiry after a single edge
    mode = 2'b00; div = '0; units = 8'd2;
    tach[1] = 1'b1;
    cyc(5);
    trig('0);
    trig(4'b0010);
    cyc(3);
    tach[1] = 1'b0;
    cyc(95);
    check("R9 not done before window", result, 32'h0);
    cyc(45);
    check("R9 expired with zero", result, 32'h8000_0000);

    // R2 abort by zero write after first edge
    mode = 2'b00; units = 8'd200;
    tach[0] = 1'b1;
    cyc(5);
    trig('0);
    trig(4'b0001);
    cyc(3);
    tach[0] = 1'b0;
    cyc(10);
    trig('0);
    tach[0] = 1'b1;
    cyc(10);
    tach[0] = 1'b0;
    cyc(50);
    check("R2 abort leaves no result", result, 32'h0);

    // R3 disabled channel
    units = 8'd2;
    trig('0);
    trig(4'b0100);
    for (int k = 0; k < 6; k++) begin
      cyc(15);
      tach[2] = ~tach[2];
    end
    cyc(200);
    check("R3 disabled channel", result, 32'h0);

    // R3 multi-bit trigger
    trig(4'b0011);
    for (int k = 0; k < 6; k++) begin
      cyc(15);
      tach[0] = ~tach[0];
    end
    cyc(200);
    check("R3 multi-bit trigger", result, 32'h0);

    // R10 saturation
    measure(0, 0, 0, 1500, 40);
    wait_done(3000);
    check("R10 saturated count", result, 32'h8000_00FF);

    // R11 hold, then R2 clear by zero write
    cyc(50);
    check("R11 result held", result, 32'h8000_00FF);
    trig('0);
    check("R2 zero write clears flag", result, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule